// File: doc/BRIEF.md
# Barrel Shifter with Flag Update

This block is the shift stage of a small processor's execute datapath. It takes a 32-bit operand and moves its bits by a chosen distance, doing a logical shift left, a logical shift right, an arithmetic shift right or a rotate right. It returns the shifted word and a new set of N, Z, C and V condition flags. The block is purely combinational, so its outputs follow its inputs in the same cycle.

The shift distance has two possible sources. In immediate mode it is a 5-bit field from the instruction. In register mode it is the low byte of a second register operand, so the distance can be anything from 0 to 255. Every distance has a defined result and a defined carry, including 32 and larger. Instruction decode, the register file and the other ALU functions belong to the surrounding datapath.

Top module: `shift_flag_unit`

## Requirements
- R1: `op_sel` picks the operation: 2'b00 logical shift left, 2'b01 logical shift right, 2'b10 arithmetic shift right, 2'b11 rotate right. For a distance from 1 to 31, `result` is the operand moved by that many places.
- R2: When `imm_mode` is 0, the distance is `amt_src[7:0]` and bits 31:8 of `amt_src` have no effect on any output.
- R3: When `imm_mode` is 1, the distance is `imm_amt`. For the two right shifts (op_sel 01 and 10), an `imm_amt` of 0 means a distance of 32. For left shift and rotate, an `imm_amt` of 0 means a distance of 0.
- R4: `n_out` equals `result[31]`, and `z_out` is 1 exactly when `result` is all zeros.
- R5: For a distance from 1 to 31, `c_out` is the last operand bit moved out. This is operand bit 32-d for a left shift and operand bit d-1 for the right shifts and the rotate.
- R6: For a distance of 0, `result` equals the operand and `c_out` equals `c_in`.
- R7: `v_out` always equals `v_in`.
- R8: A logical shift by exactly 32 gives zero. `c_out` is then operand bit 0 for a left shift and operand bit 31 for a right shift.
- R9: A logical shift by more than 32 gives zero with `c_out` cleared.
- R10: An arithmetic shift right by 32 or more fills every bit of `result` with operand bit 31, and `c_out` equals operand bit 31.
- R11: Rotate uses the distance modulo 32. A nonzero multiple of 32 leaves the operand unchanged and sets `c_out` to operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation select (encoding in R1) |
| imm_mode | input | 1 | 1: distance from imm_amt, 0: from amt_src |
| imm_amt | input | 5 | Immediate distance field |
| amt_src | input | 32 | Register holding the distance in its low byte |
| opnd | input | 32 | Value to shift |
| n_in | input | 1 | Incoming negative flag |
| z_in | input | 1 | Incoming zero flag (always replaced) |
| c_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| result | output | 32 | Shifted value |
| n_out | output | 1 | Negative flag out |
| z_out | output | 1 | Zero flag out |
| c_out | output | 1 | Carry flag out |
| v_out | output | 1 | Overflow flag out |

## Verification
The block holds no state, so any fault in its decode appears at `result` or `c_out` in the same cycle as the stimulus that exposes it. The bugs most likely to hide are a wrong mapping of the immediate 0 field, a carry index off by one, and a mishandled boundary at 32 and above. For that reason every operation is driven at distances 0, 1, 31, 32, 33 and 255 and across all immediate fields, as well as with random operands. During these runs the upper bits of the distance register are filled with noise.

// File: rtl/shift_flag_unit.sv
module shift_flag_unit (
  input  logic [1:0]  op_sel,
  input  logic        imm_mode,
  input  logic [4:0]  imm_amt,
  input  logic [31:0] amt_src,
  input  logic [31:0] opnd,
  input  logic        n_in,
  input  logic        z_in,
  input  logic        c_in,
  input  logic        v_in,
  output logic [31:0] result,
  output logic        n_out,
  output logic        z_out,
  output logic        c_out,
  output logic        v_out
);
  localparam logic [1:0] OP_LSL = 2'b00;
  localparam logic [1:0] OP_LSR = 2'b01;
  localparam logic [1:0] OP_ASR = 2'b10;
  localparam logic [1:0] OP_ROR = 2'b11;

  logic [7:0]  amt;
  logic [4:0]  a5, lidx, ridx;
  logic        is_zero, over, exact;
  logic [31:0] sh_l, sh_r, sh_a, sh_rot;
  logic        unused_in;

  assign unused_in = &{1'b0, n_in, z_in, amt_src[31:8]};

  assign amt = imm_mode
             ? (((imm_amt == 5'd0) && ((op_sel == OP_LSR) || (op_sel == OP_ASR)))
                ? 8'd32 : {3'b000, imm_amt})
             : amt_src[7:0];

  assign a5      = amt[4:0];
  assign is_zero = (amt == 8'd0);
  assign over    = |amt[7:5];
  assign exact   = (amt == 8'd32);
  assign lidx    = 5'd0 - a5;
  assign ridx    = a5 - 5'd1;

  assign sh_l   = opnd << a5;
  assign sh_r   = opnd >> a5;
  assign sh_a   = $signed(opnd) >>> a5;
  assign sh_rot = (opnd >> a5) | (opnd << (6'd32 - {1'b0, a5}));

  always_comb begin
    result = opnd;
    c_out  = c_in;
    if (!is_zero) begin
      case (op_sel)
        OP_LSL: begin
          if (!over) begin
            result = sh_l;
            c_out  = opnd[lidx];
          end else begin
            result = '0;
            c_out  = exact ? opnd[0] : 1'b0;
          end
        end
        OP_LSR: begin
          if (!over) begin
            result = sh_r;
            c_out  = opnd[ridx];
          end else begin
            result = '0;
            c_out  = exact ? opnd[31] : 1'b0;
          end
        end
        OP_ASR: begin
          if (!over) begin
            result = sh_a;
            c_out  = opnd[ridx];
          end else begin
            result = {32{opnd[31]}};
            c_out  = opnd[31];
          end
        end
        default: begin
          if (a5 == 5'd0) begin
            result = opnd;
            c_out  = opnd[31];
          end else begin
            result = sh_rot;
            c_out  = opnd[ridx];
          end
        end
      endcase
    end
  end

  assign n_out = result[31];
  assign z_out = (result == 32'd0);
  assign v_out = v_in;
endmodule

module shift_flag_unit_chk (
  input logic [1:0]  op_sel,
  input logic        imm_mode,
  input logic [4:0]  imm_amt,
  input logic [31:0] amt_src,
  input logic [31:0] opnd,
  input logic        n_in,
  input logic        z_in,
  input logic        c_in,
  input logic        v_in,
  input logic [31:0] result,
  input logic        n_out,
  input logic        z_out,
  input logic        c_out,
  input logic        v_out
);
  logic [7:0] d;
  logic       unused_chk;

  assign unused_chk = &{1'b0, n_in, z_in, amt_src[31:8], n_out, z_out};
  assign d = imm_mode ? {3'b000, imm_amt} : amt_src[7:0];

  always_comb begin
    a_r7_v_pass: assert (v_out == v_in);
    if (!imm_mode && d == 8'd0)
      a_r6_zero_keeps: assert (result == opnd && c_out == c_in);
    if (!imm_mode && d > 8'd32 && (op_sel == 2'b00 || op_sel == 2'b01))
      a_r9_logic_clear: assert (result == 32'd0 && !c_out);
    if (!imm_mode && d >= 8'd32 && op_sel == 2'b10)
      a_r10_sign_fill: assert (result == {32{opnd[31]}} && c_out == opnd[31]);
    if (!imm_mode && d != 8'd0 && d[4:0] == 5'd0 && op_sel == 2'b11)
      a_r11_rot_whole: assert (result == opnd && c_out == opnd[31]);
    if (imm_mode && imm_amt == 5'd0 && op_sel == 2'b01)
      a_r3_imm_lsr32: assert (result == 32'd0 && c_out == opnd[31]);
  end
endmodule

bind shift_flag_unit shift_flag_unit_chk i_chk (.*);

// File: tb/test_shift_flag_unit.sv
module test_shift_flag_unit;
  logic        clk = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        imm_mode = 1'b0;
  logic [4:0]  imm_amt = 5'd0;
  logic [31:0] amt_src = 32'd0;
  logic [31:0] opnd = 32'd0;
  logic        n_in = 1'b0, z_in = 1'b0, c_in = 1'b0, v_in = 1'b0;
  logic [31:0] result;
  logic        n_out, z_out, c_out, v_out;
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  shift_flag_unit i_shift_flag_unit (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic string tag_of(input logic [1:0] op, input int d, input bit imm);
    if (d == 0) return "R6";
    if (imm && imm_amt == 5'd0) return "R3";
    if (d < 32) return "R1/R5";
    if (op == 2'b11) return "R11";
    if (op == 2'b10) return "R10";
    if (d == 32) return "R8";
    return "R9";
  endfunction

  task automatic apply(input logic [1:0] op, input bit imm, input logic [4:0] ia,
                       input logic [31:0] src, input logic [31:0] x,
                       input logic ci, input logic vi);
    int d;
    logic [31:0] m;
    logic mc;
    @(posedge clk);
    op_sel = op; imm_mode = imm; imm_amt = ia; amt_src = src; opnd = x;
    c_in = ci; v_in = vi; n_in = ~x[31]; z_in = $urandom_range(0, 1);
    if (imm) d = ((op == 2'b01 || op == 2'b10) && ia == 5'd0) ? 32 : int'(ia);
    else d = int'(src[7:0]);
    m = x; mc = ci;
    for (int i = 0; i < d; i++) begin
      case (op)
        2'b00: begin mc = m[31]; m = {m[30:0], 1'b0}; end
        2'b01: begin mc = m[0];  m = {1'b0, m[31:1]}; end
        2'b10: begin mc = m[0];  m = {m[31], m[31:1]}; end
        default: begin mc = m[0]; m = {m[0], m[31:1]}; end
      endcase
    end
    @(negedge clk);
    tests++;
    if (result !== m || c_out !== mc) begin
      fails++;
      $display("FAIL %s op=%0d d=%0d x=%h: result=%h c=%b expected %h c=%b",
               tag_of(op, d, imm), op, d, x, result, c_out, m, mc);
    end
    tests++;
    if (n_out !== m[31] || z_out !== (m == 32'd0)) begin
      fails++;
      $display("FAIL R4 n=%b z=%b expected n=%b z=%b", n_out, z_out, m[31], m == 32'd0);
    end
    tests++;
    if (v_out !== vi) begin
      fails++;
      $display("FAIL R7 v=%b expected %b", v_out, vi);
    end
  endtask

  initial begin
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    logic [31:0] pats[4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
    @(negedge clk);
    tests++;
    if (result !== 32'd0 || z_out !== 1'b1 || c_out !== 1'b0) begin
      fails++;
      $display("FAIL R4 idle result=%h z=%b expected 0 z=1", result, z_out);
    end
    // R1 R5 R6 R8 R9 R10 R11: register-mode boundaries, R2: noisy upper bits
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 6; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++)
            apply(2'(o), 1'b0, 5'd0, {$urandom(), 8'(amts[a])} , pats[p], c[0], c[0]);
    // R3: every immediate field
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 32; a++)
        apply(2'(o), 1'b1, 5'(a), $urandom(), $urandom(), 1'b1, 1'b0);
    // random sweep across all distances
    for (int k = 0; k < 4000; k++)
      apply(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 5'($urandom()),
            $urandom(), $urandom(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule